// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block holds the two configuration words of a processor-core timer facility. One is a 32-bit control word that software rewrites in full. The other is a 32-bit status word whose flags are set by the timer engines and cleared by software writing ones. The block drives three interrupt lines: decrementer, fixed-interval and watchdog. Each line is high while its sticky status flag and its enable bit are both set.

The block decodes the control word into the period, period-extension, reset-control and auto-reload fields that the timer engines use. It also computes, for the fixed-interval and watchdog engines, the time-base bit position that each engine watches. It gives those two engines a one-cycle re-arm pulse whenever their configuration or their pending status changes under software control. A resume-from-halt input drops all watchdog state in the status word at once, so a long halt cannot end in a stale watchdog expiry.

Top module: `tcs_timer_regs`

## Requirements
- R1: Synchronous active-low reset sets the control word and the status word to zero. The three interrupt lines and the two re-arm pulses are low while reset is held.
- R2: A control write stores the written value in the cycle after the write. Only bits 31:22 and 20:13 are kept; bit 21 and bits 12:0 read zero. Without a write, the control word holds its value.
- R3: A status write clears each status bit whose position is 1 in the written value and leaves every other bit unchanged. The status word implements only bits 31:26; all lower bits read zero.
- R4: Event inputs set sticky status bits, visible in the next cycle:
  - decrementer event sets bit 27;
  - fixed-interval event sets bit 26;
  - watchdog event sets bit 30;
  - next-watchdog event sets bit 31;
  - the 2-bit watchdog reset code is ORed into bits 29:28.
- R5: An event that sets a status bit wins over a software clear or a resume clear of the same bit in the same cycle.
- R6: Each interrupt line is the AND of a status bit and a control enable bit:
  - decrementer: status bit 27 and control bit 26;
  - fixed-interval: status bit 26 and control bit 23;
  - watchdog: status bit 30 and control bit 27.
- R7: A resume input clears status bits 31:28 and leaves bits 27 and 26 unchanged.
- R8: The fixed-interval re-arm line is high for the cycle after a control write or a status write with bit 26 set. The watchdog re-arm line is high for the cycle after a control write, a status write with bit 30 set, or a resume.
- R9: The field outputs mirror the stored control word:
  - watchdog period [31:30];
  - watchdog reset control [29:28];
  - fixed-interval period [25:24];
  - auto-reload [22];
  - watchdog extension [20:17];
  - fixed-interval extension [16:13].
- R10: With the extended mode enabled (the default), each tap output equals 63 minus the 6-bit value {extension, period} of its engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control word write strobe |
| ctl_wr_data | input | 32 | Control word write value |
| stat_clr_en | input | 1 | Status write-one-to-clear strobe |
| stat_clr_data | input | 32 | Status bits to clear |
| resume_i | input | 1 | Resume from halt; drops watchdog status |
| ev_dec_i | input | 1 | Decrementer expiry event |
| ev_fit_i | input | 1 | Fixed-interval tap event |
| ev_wdt_i | input | 1 | Watchdog interrupt event |
| ev_wdt_next_i | input | 1 | Watchdog next-stage enable event |
| ev_wdt_rst_i | input | 2 | Watchdog reset code to record |
| ctl_q | output | 32 | Stored control word |
| stat_q | output | 32 | Stored status word |
| wdt_period_o | output | 2 | Watchdog period field |
| wdt_rst_ctl_o | output | 2 | Watchdog reset control field |
| auto_reload_o | output | 1 | Decrementer auto-reload enable |
| wdt_ext_o | output | 4 | Watchdog period extension |
| fit_period_o | output | 2 | Fixed-interval period field |
| fit_ext_o | output | 4 | Fixed-interval period extension |
| wdt_tap_o | output | 6 | Time-base bit watched by the watchdog |
| fit_tap_o | output | 6 | Time-base bit watched by the fixed-interval engine |
| irq_dec_o | output | 1 | Decrementer interrupt |
| irq_fit_o | output | 1 | Fixed-interval interrupt |
| irq_wdt_o | output | 1 | Watchdog interrupt |
| rearm_fit_o | output | 1 | Fixed-interval re-arm pulse |
| rearm_wdt_o | output | 1 | Watchdog re-arm pulse |

## Verification
Every result of this block appears one cycle after the edge that samples its cause:
- the stored words and the decoded fields and taps follow the register they derive from;
- the interrupt lines carry no input-to-output path, so they move in the same cycle as the status and control words;
- the re-arm pulses are registered, so they sit in the cycle after the write or resume.

The bench drives inputs a quarter period after a rising edge and advances its reference model on the rising edge. It compares every output at the falling edge. Each comparison therefore sees exactly one edge's worth of change.

// File: rtl/tcs_pkg.sv
// Package: shared bit positions, field struct and masks for the timer
// control/status block. Assumes a 32-bit word layout fixed by the core.
package tcs_pkg;

    localparam int WORD_W = 32;

    // Control word bit positions
    localparam int C_WPER_LO  = 30;
    localparam int C_WRC_LO   = 28;
    localparam int C_WIE      = 27;
    localparam int C_DIE      = 26;
    localparam int C_FPER_LO  = 24;
    localparam int C_FIE      = 23;
    localparam int C_ARL      = 22;
    localparam int C_WEXT_LO  = 17;
    localparam int C_FEXT_LO  = 13;

    // Status word bit positions
    localparam int S_WNEXT    = 31;
    localparam int S_WINT     = 30;
    localparam int S_WRST_LO  = 28;
    localparam int S_DINT     = 27;
    localparam int S_FINT     = 26;

    localparam logic [WORD_W-1:0] CTL_MASK_BASE = 32'hFFC0_0000;
    localparam logic [WORD_W-1:0] CTL_MASK_EXT  = 32'h001F_E000;
    localparam logic [WORD_W-1:0] STAT_MASK     = 32'hFC00_0000;
    localparam logic [WORD_W-1:0] STAT_WDOG_ALL = 32'hF000_0000;

    typedef struct packed {
        logic [1:0] wdt_per;
        logic [1:0] wdt_rst_ctl;
        logic       wdt_ie;
        logic       dec_ie;
        logic [1:0] fit_per;
        logic       fit_ie;
        logic       auto_reload;
        logic [3:0] wdt_ext;
        logic [3:0] fit_ext;
    } tcs_ctl_t;

endpackage

// File: rtl/tcs_ctl_reg.sv
// Module: control word storage and field decode.
// Holds the control word written in full by software, with unimplemented
// bits forced to zero, and computes the time-base tap of each engine.
// Assumes: extension fields exist only when EXT_MODE is 1; otherwise a
// per-engine table of four tap positions indexed by the period field.
module tcs_ctl_reg
    import tcs_pkg::*;
#(
    parameter bit          EXT_MODE = 1'b1,
    parameter int          TAP_W    = 6,
    parameter int          TAP_TOP  = 63,
    parameter logic [4*TAP_W-1:0] FIT_TAPS = {6'd21, 6'd17, 6'd13, 6'd9},
    parameter logic [4*TAP_W-1:0] WDT_TAPS = {6'd33, 6'd29, 6'd25, 6'd21}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] ctl_q,
    output tcs_ctl_t          fields,
    output logic [TAP_W-1:0]  fit_tap,
    output logic [TAP_W-1:0]  wdt_tap
);

    localparam logic [WORD_W-1:0] MASK =
        EXT_MODE ? (CTL_MASK_BASE | CTL_MASK_EXT) : CTL_MASK_BASE;
    localparam logic [TAP_W-1:0]  TOP_V = TAP_W'(TAP_TOP);

    logic [WORD_W-1:0] ctl_r;

    // Purpose: store a full control write, keeping only implemented bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r <= '0;
        end else if (wr_en) begin
            ctl_r <= wr_data & MASK;
        end
    end

    assign ctl_q = ctl_r;

    // Purpose: split the stored word into the fields the engines consume.
    always_comb begin
        fields.wdt_per     = ctl_r[C_WPER_LO +: 2];
        fields.wdt_rst_ctl = ctl_r[C_WRC_LO +: 2];
        fields.wdt_ie      = ctl_r[C_WIE];
        fields.dec_ie      = ctl_r[C_DIE];
        fields.fit_per     = ctl_r[C_FPER_LO +: 2];
        fields.fit_ie      = ctl_r[C_FIE];
        fields.auto_reload = ctl_r[C_ARL];
        fields.wdt_ext     = ctl_r[C_WEXT_LO +: 4];
        fields.fit_ext     = ctl_r[C_FEXT_LO +: 4];
    end

    generate
        if (EXT_MODE) begin : g_ext_taps
            // Purpose: tap = top bit minus the combined extension/period code.
            always_comb begin
                fit_tap = TOP_V - TAP_W'({fields.fit_ext, fields.fit_per});
                wdt_tap = TOP_V - TAP_W'({fields.wdt_ext, fields.wdt_per});
            end
        end else begin : g_tbl_taps
            // Purpose: tap looked up from the per-engine table by period.
            always_comb begin
                fit_tap = FIT_TAPS[fields.fit_per * TAP_W +: TAP_W];
                wdt_tap = WDT_TAPS[fields.wdt_per * TAP_W +: TAP_W];
            end
        end
    endgenerate

    assert_ctl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == ($past(wr_data) & MASK)));

    assert_ctl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctl_q));

    assert_ctl_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (ctl_q == '0));

endmodule

// File: rtl/tcs_stat_reg.sv
// Module: sticky status word.
// Events set bits; software write-one-to-clear and resume clear them.
// A set in the same cycle as a clear wins, so no event is lost.
// Assumes events are single-cycle or level; both are merely ORed in.
module tcs_stat_reg
    import tcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_en,
    input  logic [WORD_W-1:0] clr_data,
    input  logic              resume,
    input  logic              ev_dec,
    input  logic              ev_fit,
    input  logic              ev_wdt,
    input  logic              ev_wnext,
    input  logic [1:0]        ev_wrst,
    output logic [WORD_W-1:0] stat_q
);

    logic [WORD_W-1:0] stat_r;
    logic [WORD_W-1:0] set_v;
    logic [WORD_W-1:0] clr_v;

    // Purpose: gather event inputs into their status bit positions.
    always_comb begin
        set_v                  = '0;
        set_v[S_WNEXT]         = ev_wnext;
        set_v[S_WINT]          = ev_wdt;
        set_v[S_WRST_LO +: 2]  = ev_wrst;
        set_v[S_DINT]          = ev_dec;
        set_v[S_FINT]          = ev_fit;
    end

    // Purpose: gather software and resume clear requests.
    always_comb begin
        clr_v = (clr_en ? clr_data : '0) | (resume ? STAT_WDOG_ALL : '0);
    end

    // Purpose: update sticky bits, set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_r <= '0;
        end else begin
            stat_r <= ((stat_r & ~clr_v) | set_v) & STAT_MASK;
        end
    end

    assign stat_q = stat_r;

    assert_evt_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fit && clr_en && clr_data[S_FINT]) |=> stat_q[S_FINT]);

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_data[S_DINT] && !ev_dec) |=> !stat_q[S_DINT]);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[S_DINT] && !(clr_en && clr_data[S_DINT])) |=> stat_q[S_DINT]);

    assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && !ev_wdt && !ev_wnext && ev_wrst == 2'b00)
        |=> (stat_q[31:28] == 4'h0));

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[25:0] == '0);

    assert_stat_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0));

endmodule

// File: rtl/tcs_irq_rearm.sv
// Module: interrupt combiner and engine re-arm pulse generator.
// Interrupt lines are status AND enable, purely from stored state.
// Re-arm pulses are registered one cycle after the triggering write.
// Assumes its callers present single bits already decoded from the words.
module tcs_irq_rearm (
    input  logic clk,
    input  logic rst_n,
    input  logic st_dint,
    input  logic st_fint,
    input  logic st_wint,
    input  logic en_dec,
    input  logic en_fit,
    input  logic en_wdt,
    input  logic ctl_wr_en,
    input  logic clr_en,
    input  logic clr_fint,
    input  logic clr_wint,
    input  logic resume,
    output logic irq_dec,
    output logic irq_fit,
    output logic irq_wdt,
    output logic rearm_fit,
    output logic rearm_wdt
);

    logic rf_r;
    logic rw_r;

    // Purpose: qualify each sticky flag with its enable.
    always_comb begin
        irq_dec = st_dint & en_dec;
        irq_fit = st_fint & en_fit;
        irq_wdt = st_wint & en_wdt;
    end

    // Purpose: register one-cycle re-arm requests for the two engines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_r <= 1'b0;
            rw_r <= 1'b0;
        end else begin
            rf_r <= ctl_wr_en | (clr_en & clr_fint);
            rw_r <= ctl_wr_en | (clr_en & clr_wint) | resume;
        end
    end

    assign rearm_fit = rf_r;
    assign rearm_wdt = rw_r;

    assert_rearm_fit_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_fit |-> $past(ctl_wr_en || (clr_en && clr_fint)));

    assert_rearm_wdt_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> rearm_wdt);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !st_fint |-> !irq_fit);

    assert_irq_reset_R1: assert property (@(posedge clk)
        !rst_n |=> !(rearm_fit || rearm_wdt));

endmodule

// File: rtl/tcs_timer_regs.sv
// Module: top of the timer control/status register block.
// Connects control storage, sticky status and the interrupt/re-arm logic,
// and exports decoded fields and taps to the timer engines.
// Assumes the time base and engine counters live outside this block.
module tcs_timer_regs
    import tcs_pkg::*;
#(
    parameter bit EXT_MODE = 1'b1,
    parameter int TAP_W    = 6,
    parameter int TAP_TOP  = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_en,
    input  logic [31:0] ctl_wr_data,
    input  logic        stat_clr_en,
    input  logic [31:0] stat_clr_data,
    input  logic        resume_i,
    input  logic        ev_dec_i,
    input  logic        ev_fit_i,
    input  logic        ev_wdt_i,
    input  logic        ev_wdt_next_i,
    input  logic [1:0]  ev_wdt_rst_i,
    output logic [31:0] ctl_q,
    output logic [31:0] stat_q,
    output logic [1:0]  wdt_period_o,
    output logic [1:0]  wdt_rst_ctl_o,
    output logic        auto_reload_o,
    output logic [3:0]  wdt_ext_o,
    output logic [1:0]  fit_period_o,
    output logic [3:0]  fit_ext_o,
    output logic [5:0]  wdt_tap_o,
    output logic [5:0]  fit_tap_o,
    output logic        irq_dec_o,
    output logic        irq_fit_o,
    output logic        irq_wdt_o,
    output logic        rearm_fit_o,
    output logic        rearm_wdt_o
);

    tcs_ctl_t          fld;
    logic [TAP_W-1:0]  fit_tap_w;
    logic [TAP_W-1:0]  wdt_tap_w;

    tcs_ctl_reg #(
        .EXT_MODE (EXT_MODE),
        .TAP_W    (TAP_W),
        .TAP_TOP  (TAP_TOP)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl_q   (ctl_q),
        .fields  (fld),
        .fit_tap (fit_tap_w),
        .wdt_tap (wdt_tap_w)
    );

    tcs_stat_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (stat_clr_en),
        .clr_data (stat_clr_data),
        .resume   (resume_i),
        .ev_dec   (ev_dec_i),
        .ev_fit   (ev_fit_i),
        .ev_wdt   (ev_wdt_i),
        .ev_wnext (ev_wdt_next_i),
        .ev_wrst  (ev_wdt_rst_i),
        .stat_q   (stat_q)
    );

    tcs_irq_rearm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_dint   (stat_q[S_DINT]),
        .st_fint   (stat_q[S_FINT]),
        .st_wint   (stat_q[S_WINT]),
        .en_dec    (fld.dec_ie),
        .en_fit    (fld.fit_ie),
        .en_wdt    (fld.wdt_ie),
        .ctl_wr_en (ctl_wr_en),
        .clr_en    (stat_clr_en),
        .clr_fint  (stat_clr_data[S_FINT]),
        .clr_wint  (stat_clr_data[S_WINT]),
        .resume    (resume_i),
        .irq_dec   (irq_dec_o),
        .irq_fit   (irq_fit_o),
        .irq_wdt   (irq_wdt_o),
        .rearm_fit (rearm_fit_o),
        .rearm_wdt (rearm_wdt_o)
    );

    // Purpose: present decoded fields and taps at the block edge.
    always_comb begin
        wdt_period_o  = fld.wdt_per;
        wdt_rst_ctl_o = fld.wdt_rst_ctl;
        auto_reload_o = fld.auto_reload;
        wdt_ext_o     = fld.wdt_ext;
        fit_period_o  = fld.fit_per;
        fit_ext_o     = fld.fit_ext;
        wdt_tap_o     = 6'(wdt_tap_w);
        fit_tap_o     = 6'(fit_tap_w);
    end

endmodule

// File: tb/tcs_timer_regs_test.sv
module tcs_timer_regs_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wr_data = '0;
    logic        stat_clr_en = 1'b0;
    logic [31:0] stat_clr_data = '0;
    logic        resume_i = 1'b0;
    logic        ev_dec_i = 1'b0;
    logic        ev_fit_i = 1'b0;
    logic        ev_wdt_i = 1'b0;
    logic        ev_wdt_next_i = 1'b0;
    logic [1:0]  ev_wdt_rst_i = 2'b00;

    logic [31:0] ctl_q, stat_q;
    logic [1:0]  wdt_period_o, wdt_rst_ctl_o, fit_period_o;
    logic        auto_reload_o;
    logic [3:0]  wdt_ext_o, fit_ext_o;
    logic [5:0]  wdt_tap_o, fit_tap_o;
    logic        irq_dec_o, irq_fit_o, irq_wdt_o, rearm_fit_o, rearm_wdt_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit model_live = 1'b0;

    // reference model state
    bit [31:0] m_ctl;
    bit [31:0] m_stat;
    bit        m_rf, m_rw;

    tcs_timer_regs uut (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .stat_clr_en(stat_clr_en), .stat_clr_data(stat_clr_data),
        .resume_i(resume_i), .ev_dec_i(ev_dec_i), .ev_fit_i(ev_fit_i),
        .ev_wdt_i(ev_wdt_i), .ev_wdt_next_i(ev_wdt_next_i),
        .ev_wdt_rst_i(ev_wdt_rst_i),
        .ctl_q(ctl_q), .stat_q(stat_q),
        .wdt_period_o(wdt_period_o), .wdt_rst_ctl_o(wdt_rst_ctl_o),
        .auto_reload_o(auto_reload_o), .wdt_ext_o(wdt_ext_o),
        .fit_period_o(fit_period_o), .fit_ext_o(fit_ext_o),
        .wdt_tap_o(wdt_tap_o), .fit_tap_o(fit_tap_o),
        .irq_dec_o(irq_dec_o), .irq_fit_o(irq_fit_o), .irq_wdt_o(irq_wdt_o),
        .rearm_fit_o(rearm_fit_o), .rearm_wdt_o(rearm_wdt_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advanced on each rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = 0; m_stat = 0; m_rf = 0; m_rw = 0;
        end else begin
            bit [31:0] nxt;
            nxt = m_stat;
            if (stat_clr_en) nxt = nxt & ~stat_clr_data;        // R3
            if (resume_i) nxt[31:28] = 4'h0;                    // R7
            if (ev_wdt_next_i) nxt[31] = 1;                     // R4, R5
            if (ev_wdt_i) nxt[30] = 1;
            nxt[29:28] = nxt[29:28] | ev_wdt_rst_i;
            if (ev_dec_i) nxt[27] = 1;
            if (ev_fit_i) nxt[26] = 1;
            nxt[25:0] = 0;
            m_stat = nxt;
            m_rf = ctl_wr_en || (stat_clr_en && stat_clr_data[26]);          // R8
            m_rw = ctl_wr_en || (stat_clr_en && stat_clr_data[30]) || resume_i;
            if (ctl_wr_en) begin                                // R2
                m_ctl = ctl_wr_data;
                m_ctl[21] = 0;
                m_ctl[12:0] = 0;
            end
        end
        model_live = 1'b1;
    end

    // Compare every output with the model at the falling edge.
    always @(negedge clk) begin
        if (model_live) begin
            int ftap, wtap;
            ftap = 63 - ((m_ctl[16:13] << 2) | m_ctl[25:24]);
            wtap = 63 - ((m_ctl[20:17] << 2) | m_ctl[31:30]);
            chk("R2 ctl_q", ctl_q, m_ctl);
            chk("R3 R4 stat_q", stat_q, m_stat);
            chk("R6 irq_dec", 32'(irq_dec_o), 32'(m_stat[27] & m_ctl[26]));
            chk("R6 irq_fit", 32'(irq_fit_o), 32'(m_stat[26] & m_ctl[23]));
            chk("R6 irq_wdt", 32'(irq_wdt_o), 32'(m_stat[30] & m_ctl[27]));
            chk("R8 rearm_fit", 32'(rearm_fit_o), 32'(m_rf));
            chk("R8 rearm_wdt", 32'(rearm_wdt_o), 32'(m_rw));
            chk("R9 fields",
                {16'd0, wdt_period_o, wdt_rst_ctl_o, fit_period_o, auto_reload_o,
                 wdt_ext_o, fit_ext_o, 1'b0},
                {16'd0, m_ctl[31:30], m_ctl[29:28], m_ctl[25:24], m_ctl[22],
                 m_ctl[20:17], m_ctl[16:13], 1'b0});
            chk("R10 fit_tap", 32'(fit_tap_o), 32'(ftap[5:0]));
            chk("R10 wdt_tap", 32'(wdt_tap_o), 32'(wtap[5:0]));
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic idle_inputs();
        ctl_wr_en = 0; stat_clr_en = 0; resume_i = 0;
        ev_dec_i = 0; ev_fit_i = 0; ev_wdt_i = 0; ev_wdt_next_i = 0;
        ev_wdt_rst_i = 2'b00;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R1: reset state, directly
        chk("R1 reset ctl", ctl_q, 32'h0);
        chk("R1 reset stat", stat_q, 32'h0);
        chk("R1 reset irqs", {29'd0, irq_dec_o, irq_fit_o, irq_wdt_o}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R2: all-ones write keeps only implemented bits
        ctl_wr_en = 1; ctl_wr_data = 32'hFFFF_FFFF;
        tick(); idle_inputs();
        #1 chk("R2 masked write", ctl_q, 32'hFFDF_E000);
        chk("R8 rearm after ctl write", {30'd0, rearm_fit_o, rearm_wdt_o}, 32'h3);
        tick();
        chk("R8 rearm one cycle", {30'd0, rearm_fit_o, rearm_wdt_o}, 32'h0);

        // R4 / R6: events set status and raise interrupts
        ev_dec_i = 1; ev_fit_i = 1; ev_wdt_i = 1; ev_wdt_next_i = 1; ev_wdt_rst_i = 2'b10;
        tick(); idle_inputs();
        chk("R4 events set", stat_q, 32'hEC00_0000);
        chk("R6 all irqs", {29'd0, irq_dec_o, irq_fit_o, irq_wdt_o}, 32'h7);

        // R5: fixed-interval event against a same-cycle clear
        stat_clr_en = 1; stat_clr_data = 32'h0400_0000; ev_fit_i = 1;
        tick(); idle_inputs();
        chk("R5 event beats clear", 32'(stat_q[26]), 32'h1);
        chk("R8 rearm_fit on clear", 32'(rearm_fit_o), 32'h1);

        // R3: clear only the decrementer bit
        stat_clr_en = 1; stat_clr_data = 32'h0800_0000;
        tick(); idle_inputs();
        chk("R3 w1c selective", stat_q, 32'hE400_0000);
        chk("R6 irq_dec dropped", 32'(irq_dec_o), 32'h0);

        // R7: resume drops watchdog bits only
        resume_i = 1;
        tick(); idle_inputs();
        chk("R7 resume", stat_q, 32'h0400_0000);
        chk("R8 rearm_wdt on resume", 32'(rearm_wdt_o), 32'h1);

        // R10: tap for a chosen extension/period
        ctl_wr_en = 1; ctl_wr_data = 32'h4100_A000; // wper=1, fper=1, fext=5
        tick(); idle_inputs();
        chk("R10 fit tap", 32'(fit_tap_o), 32'd42);
        chk("R10 wdt tap", 32'(wdt_tap_o), 32'd62);

        // randomized traffic, checked every cycle by the model
        for (int i = 0; i < 3000; i++) begin
            ctl_wr_en     = ($urandom % 8) == 0;
            ctl_wr_data   = $urandom;
            stat_clr_en   = ($urandom % 4) == 0;
            stat_clr_data = $urandom;
            resume_i      = ($urandom % 16) == 0;
            ev_dec_i      = ($urandom % 5) == 0;
            ev_fit_i      = ($urandom % 5) == 0;
            ev_wdt_i      = ($urandom % 6) == 0;
            ev_wdt_next_i = ($urandom % 6) == 0;
            ev_wdt_rst_i  = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1503) rst_n = 1'b1;
            tick();
        end
        idle_inputs();
        repeat (2) tick();
        finish_run();
    end

endmodule